// File: doc/BRIEF.md
# Flash Reset Command and Abort Controller

This block follows the operating mode of a flash array and decides what a reset request does to it. It watches the processor's write cycles for a reset command, written either on its own or after a two-write unlock prefix. It also watches a hardware reset pin. The effect of a reset depends on what the array is doing at that moment:

- It is dropped while a program or a whole-array erase is running.
- It cancels a sector erase, with a bounded recovery time.
- It clears a latched error condition.
- It takes the array out of the identifier / protection-read mode.

An external erase/program engine reports whether it is busy and which kind of operation it is running. It also pulses a failure indication, and a separate command path pulses a request to enter identifier mode. The controller answers with the current mode, an error flag, a one-cycle abort request to the engine, and a ready signal. Ready stays low for a parameterised number of clock cycles while the array recovers after an abort or an error clear.

Top module: `flash_rst_ctrl`

## Requirements
- R1: After synchronous reset, mode is 0 (normal read), err_flag is 0, abort_req is 0 and ready is 1.
- R2: A single write of data F0h to any address is a reset command. Taken in identifier mode (mode 1) with the engine idle, it sets mode to 0 on the second rising edge after the write, and ready stays 1.
- R3: The unlock prefix has two writes: data AAh to address 555h, then data 55h to address AAAh. A prefix followed by a write of F0h is accepted with the same effect as a bare F0h write.
- R4: A broken prefix returns the sequence detector to idle and leaves the mode unchanged. That means a first write of AAh to 555h followed by anything other than 55h at AAAh, or a full prefix followed by data other than F0h. The write that breaks the prefix is itself not taken as a command.
- R5: A pulse on enter_id while mode is 0 and the engine is idle sets mode to 1.
- R6: A pulse on eng_fail sets mode to 2 and err_flag to 1. A reset command with the engine idle then clears err_flag, sets mode to 3 (recovering) with ready at 0 for exactly RECOV_CYC cycles, and afterwards sets mode to 0 with ready at 1.
- R7: A reset command while eng_busy is 1 and eng_op is 0 (program) or 1 (whole-array erase) is ignored. The mode is unchanged, abort_req stays 0 and ready stays 1.
- R8: A reset command while eng_busy is 1 and eng_op is 2 (sector erase) produces a one-cycle abort_req pulse. Mode is then 3 with ready at 0 for exactly RECOV_CYC cycles, followed by mode 0.
- R9: While rst_pin is 1 and the engine is busy, abort_req pulses once and recovery is held. Ready returns to 1 with mode 0 no later than RECOV_CYC cycles after rst_pin falls. With the engine idle, rst_pin sets mode to 0 and clears err_flag on the next edge, and ready stays 1.
- R10: Reset commands written during recovery are accepted but do not restart the recovery count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rst_pin | input | 1 | Hardware reset request, active high |
| eng_busy | input | 1 | Engine has an operation running |
| eng_op | input | 2 | Running operation: 0 program, 1 whole-array erase, 2 sector erase |
| eng_fail | input | 1 | One-cycle pulse: the engine's operation failed |
| enter_id | input | 1 | One-cycle pulse: enter identifier / protection-read mode |
| mode | output | 2 | 0 read, 1 identifier, 2 error, 3 recovering |
| err_flag | output | 1 | Error condition latched |
| abort_req | output | 1 | One-cycle request to the engine to stop |
| ready | output | 1 | Low while recovery is counting |

## Verification
The write patterns include:

- a bare F0h command;
- a full unlock prefix followed by F0h;
- a prefix broken at its second write;
- a full prefix ending in a wrong command byte;
- stray writes of other data.

Together these separate a detector that accepts a bare command from one that demands the prefix, and show whether a breaking write is wrongly consumed as a command. The same command is also issued under each engine operation type and in each mode, which separates the ignore, abort and error-clear responses. The recovery window is counted cycle by cycle, with an extra command injected mid-window, to expose any restart of the count.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_ID    = 2'd1,
    MODE_ERR   = 2'd2,
    MODE_RECOV = 2'd3
  } fmode_t;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_BULK  = 2'd1,
    OP_SECT  = 2'd2,
    OP_RSVD  = 2'd3
  } eop_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_KEY1 = 2'd1,
    SEQ_KEY2 = 2'd2
  } seq_t;

endpackage

// File: rtl/fcmd_seq_det.sv
module fcmd_seq_det
  import flash_rst_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int KEY_A1  = 'h555,
  parameter int KEY_A2  = 'hAAA,
  parameter int KEY_D1  = 'hAA,
  parameter int KEY_D2  = 'h55,
  parameter int CMD_RST = 'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_hit
);

  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(KEY_A1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(KEY_A2);
  localparam logic [DATA_W-1:0] D1 = DATA_W'(KEY_D1);
  localparam logic [DATA_W-1:0] D2 = DATA_W'(KEY_D2);
  localparam logic [DATA_W-1:0] DC = DATA_W'(CMD_RST);

  seq_t st_q, st_d;
  logic hit_d;

  always_comb begin
    st_d  = st_q;
    hit_d = 1'b0;
    if (wr_stb) begin
      unique case (st_q)
        SEQ_KEY1: st_d = (wr_addr == A2 && wr_data == D2) ? SEQ_KEY2 : SEQ_IDLE;
        SEQ_KEY2: begin
          hit_d = (wr_data == DC);
          st_d  = SEQ_IDLE;
        end
        default: begin
          if (wr_data == DC) begin
            hit_d = 1'b1;
            st_d  = SEQ_IDLE;
          end else if (wr_addr == A1 && wr_data == D1) begin
            st_d = SEQ_KEY1;
          end else begin
            st_d = SEQ_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SEQ_IDLE;
      cmd_hit <= 1'b0;
    end else begin
      st_q    <= st_d;
      cmd_hit <= hit_d;
    end
  end

endmodule

// File: rtl/frecov_timer.sv
module frecov_timer #(
  parameter int RECOV_CYC = 3125
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic zero
);

  localparam int CNT_W = (RECOV_CYC > 1) ? $clog2(RECOV_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RECOV_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_V;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/fmode_ctrl.sv
module fmode_ctrl
  import flash_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_hit,
  input  logic       rst_pin,
  input  logic       eng_busy,
  input  logic [1:0] eng_op,
  input  logic       eng_fail,
  input  logic       enter_id,
  input  logic       tmr_zero,
  output logic       tmr_load,
  output logic [1:0] mode,
  output logic       err_flag,
  output logic       abort_req,
  output logic       ready
);

  fmode_t m_q, m_d;
  logic   abort_d;
  logic   sect_op;

  assign sect_op = (eng_op == OP_SECT);

  always_comb begin
    m_d      = m_q;
    abort_d  = 1'b0;
    tmr_load = 1'b0;
    if (rst_pin) begin
      if (eng_busy || m_q == MODE_RECOV) begin
        m_d      = MODE_RECOV;
        tmr_load = 1'b1;
        abort_d  = eng_busy && (m_q != MODE_RECOV);
      end else begin
        m_d = MODE_READ;
      end
    end else if (m_q == MODE_RECOV) begin
      if (tmr_zero) m_d = MODE_READ;
    end else if (eng_fail) begin
      m_d = MODE_ERR;
    end else if (cmd_hit) begin
      if (eng_busy) begin
        if (sect_op) begin
          m_d      = MODE_RECOV;
          tmr_load = 1'b1;
          abort_d  = 1'b1;
        end
      end else if (m_q == MODE_ERR) begin
        m_d      = MODE_RECOV;
        tmr_load = 1'b1;
      end else if (m_q == MODE_ID) begin
        m_d = MODE_READ;
      end
    end else if (enter_id && !eng_busy && m_q == MODE_READ) begin
      m_d = MODE_ID;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q       <= MODE_READ;
      err_flag  <= 1'b0;
      abort_req <= 1'b0;
      ready     <= 1'b1;
    end else begin
      m_q       <= m_d;
      err_flag  <= (m_d == MODE_ERR);
      abort_req <= abort_d;
      ready     <= (m_d != MODE_RECOV);
    end
  end

  assign mode = m_q;

endmodule

// File: rtl/flash_rst_ctrl.sv
module flash_rst_ctrl
  import flash_rst_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int RECOV_CYC = 3125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rst_pin,
  input  logic              eng_busy,
  input  logic [1:0]        eng_op,
  input  logic              eng_fail,
  input  logic              enter_id,
  output logic [1:0]        mode,
  output logic              err_flag,
  output logic              abort_req,
  output logic              ready
);

  logic cmd_hit;
  logic tmr_load;
  logic tmr_zero;

  fcmd_seq_det #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_det (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmd_hit (cmd_hit)
  );

  frecov_timer #(
    .RECOV_CYC (RECOV_CYC)
  ) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .zero (tmr_zero)
  );

  fmode_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_hit   (cmd_hit),
    .rst_pin   (rst_pin),
    .eng_busy  (eng_busy),
    .eng_op    (eng_op),
    .eng_fail  (eng_fail),
    .enter_id  (enter_id),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .mode      (mode),
    .err_flag  (err_flag),
    .abort_req (abort_req),
    .ready     (ready)
  );

endmodule

// File: rtl/flash_rst_chk.sv
module flash_rst_chk #(
  parameter int RECOV_CYC = 3125
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_hit,
  input logic       rst_pin,
  input logic       eng_busy,
  input logic [1:0] eng_op,
  input logic       eng_fail,
  input logic [1:0] mode,
  input logic       err_flag,
  input logic       abort_req,
  input logic       ready
);

  int low_run;

  always_ff @(posedge clk) begin
    if (rst || ready || rst_pin) low_run <= 0;
    else                         low_run <= low_run + 1;
  end

  assert_abort_single_R8: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> !abort_req);

  assert_abort_cause_R9: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> $past(eng_busy));

  assert_ignore_prog_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && eng_busy && eng_op != 2'd2 && !rst_pin && !eng_fail && mode != 2'd3)
      |=> ($stable(mode) && !abort_req));

  assert_recov_bound_R6: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (low_run <= RECOV_CYC));

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> $past(eng_fail));

  assert_ready_read_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (mode == 2'd0));

endmodule

bind flash_rst_ctrl flash_rst_chk #(.RECOV_CYC(RECOV_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_hit   (cmd_hit),
  .rst_pin   (rst_pin),
  .eng_busy  (eng_busy),
  .eng_op    (eng_op),
  .eng_fail  (eng_fail),
  .mode      (mode),
  .err_flag  (err_flag),
  .abort_req (abort_req),
  .ready     (ready)
);

// File: tb/test_flash_rst_ctrl.sv
`timescale 1ns/1ps
module test_flash_rst_ctrl;

  localparam int AW = 12;
  localparam int DW = 8;
  localparam int N  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rst_pin = 1'b0;
  logic          eng_busy = 1'b0;
  logic [1:0]    eng_op = 2'd0;
  logic          eng_fail = 1'b0;
  logic          enter_id = 1'b0;
  logic [1:0]    mode;
  logic          err_flag;
  logic          abort_req;
  logic          ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  flash_rst_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RECOV_CYC(N)) i_flash_rst_ctrl (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_pin(rst_pin), .eng_busy(eng_busy), .eng_op(eng_op), .eng_fail(eng_fail),
    .enter_id(enter_id), .mode(mode), .err_flag(err_flag), .abort_req(abort_req),
    .ready(ready)
  );

  // kind: 0 write, 1 enter_id pulse, 2 eng_fail pulse, 3 wait N cycles
  // fields {kind[1:0], addr[11:0], data[7:0], exp_mode[1:0], exp_ready}
  localparam logic [24:0] VEC [0:18] = '{
    {2'd1, 12'h000, 8'h00, 2'd1, 1'b1},  // R5
    {2'd0, 12'h123, 8'hF0, 2'd0, 1'b1},  // R2
    {2'd1, 12'h000, 8'h00, 2'd1, 1'b1},
    {2'd0, 12'h555, 8'hAA, 2'd1, 1'b1},
    {2'd0, 12'hAAA, 8'h55, 2'd1, 1'b1},
    {2'd0, 12'h000, 8'hF0, 2'd0, 1'b1},  // R3
    {2'd1, 12'h000, 8'h00, 2'd1, 1'b1},
    {2'd0, 12'h555, 8'hAA, 2'd1, 1'b1},
    {2'd0, 12'hAAA, 8'hF0, 2'd1, 1'b1},  // R4 broken prefix
    {2'd0, 12'h007, 8'hF0, 2'd0, 1'b1},  // R2 after break
    {2'd1, 12'h000, 8'h00, 2'd1, 1'b1},
    {2'd0, 12'h555, 8'hAA, 2'd1, 1'b1},
    {2'd0, 12'hAAA, 8'h55, 2'd1, 1'b1},
    {2'd0, 12'h555, 8'h77, 2'd1, 1'b1},  // R4 wrong command byte
    {2'd0, 12'h000, 8'h12, 2'd1, 1'b1},  // R4 stray write
    {2'd2, 12'h000, 8'h00, 2'd2, 1'b1},  // R6 error
    {2'd0, 12'h555, 8'hF0, 2'd3, 1'b0},  // R6 clear starts recovery
    {2'd3, 12'h000, 8'h00, 2'd0, 1'b1},  // R6 recovery done
    {2'd0, 12'h000, 8'hF0, 2'd0, 1'b1}   // R2 no effect in read mode
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic pulse_id();
    enter_id = 1'b1;
    @(negedge clk);
    enter_id = 1'b0;
  endtask

  task automatic pulse_fail();
    eng_fail = 1'b1;
    @(negedge clk);
    eng_fail = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int low;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 err_flag", err_flag, 0);
    chk("R1 abort_req", abort_req, 0);
    chk("R1 ready", ready, 1);

    for (int i = 0; i < 19; i++) begin
      logic [24:0] v;
      v = VEC[i];
      case (v[24:23])
        2'd0: wr(v[22:11], v[10:3]);
        2'd1: pulse_id();
        2'd2: pulse_fail();
        default: repeat (N - 1) @(negedge clk);
      endcase
      @(negedge clk);
      chk($sformatf("R2-vector %0d mode", i), mode, int'(v[2:1]));
      chk($sformatf("R6-vector %0d ready", i), ready, int'(v[0]));
    end

    // R6 and R10: exact recovery length, extra command mid-window
    pulse_fail();
    chk("R6 err_flag set", err_flag, 1);
    wr(12'h000, 8'hF0);
    @(negedge clk);
    chk("R6 err_flag cleared", err_flag, 0);
    chk("R6 recovering mode", mode, 3);
    low = ready ? 0 : 1;
    for (int i = 0; i < N + 4; i++) begin
      if (i == 2) begin
        wr_stb = 1'b1; wr_addr = 12'h000; wr_data = 8'hF0;
      end else begin
        wr_stb = 1'b0;
      end
      @(negedge clk);
      if (!ready) low++;
    end
    wr_stb = 1'b0;
    chk("R10 ready-low length", low, N);
    chk("R10 mode after recovery", mode, 0);

    // R7: ignored during program and whole-array erase
    pulse_id();
    eng_busy = 1'b1; eng_op = 2'd0;
    wr(12'h000, 8'hF0);
    @(negedge clk);
    chk("R7 prog mode", mode, 1);
    chk("R7 prog abort", abort_req, 0);
    chk("R7 prog ready", ready, 1);
    eng_op = 2'd1;
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h000, 8'hF0);
    @(negedge clk);
    chk("R7 bulk mode", mode, 1);
    chk("R7 bulk abort", abort_req, 0);
    eng_busy = 1'b0;
    wr(12'h000, 8'hF0);
    @(negedge clk);
    chk("R2 after busy", mode, 0);

    // R8: sector erase abort
    eng_busy = 1'b1; eng_op = 2'd2;
    wr(12'h2AA, 8'hF0);
    @(negedge clk);
    chk("R8 abort pulse", abort_req, 1);
    chk("R8 mode", mode, 3);
    chk("R8 ready low", ready, 0);
    eng_busy = 1'b0;
    @(negedge clk);
    chk("R8 abort single", abort_req, 0);
    repeat (N - 2) @(negedge clk);
    chk("R8 still recovering", ready, 0);
    repeat (2) @(negedge clk);
    chk("R8 ready back", ready, 1);
    chk("R8 mode read", mode, 0);

    // R9: pin while busy
    eng_busy = 1'b1; eng_op = 2'd0;
    rst_pin = 1'b1;
    @(negedge clk);
    chk("R9 abort pulse", abort_req, 1);
    chk("R9 ready low", ready, 0);
    eng_busy = 1'b0;
    @(negedge clk);
    chk("R9 abort single", abort_req, 0);
    @(negedge clk);
    rst_pin = 1'b0;
    repeat (N - 1) @(negedge clk);
    chk("R9 held recovery", ready, 0);
    @(negedge clk);
    chk("R9 ready back", ready, 1);
    chk("R9 mode read", mode, 0);

    // R9: pin with engine idle
    pulse_id();
    chk("R5 id mode", mode, 1);
    rst_pin = 1'b1;
    @(negedge clk);
    rst_pin = 1'b0;
    chk("R9 idle pin mode", mode, 0);
    chk("R9 idle pin ready", ready, 1);
    chk("R9 idle pin abort", abort_req, 0);
    pulse_fail();
    rst_pin = 1'b1;
    @(negedge clk);
    rst_pin = 1'b0;
    chk("R9 pin clears err", err_flag, 0);
    chk("R9 pin err mode", mode, 0);

    finish_run();
  end

endmodule